// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block derives a CPU clock, a gated PCI clock, a free-running PCI clock and a reference clock from one fast master clock. It uses synchronous dividers and registered output gating. A two-bit strap, built from a speed select and an active-low tristate/test pin, picks one of four modes. The modes are: outputs disabled (high impedance), a slow CPU mode at master/3, a fast CPU mode at master/2, and a test mode in which an external test clock is divided instead of the master clock. In both normal modes the PCI clocks run at master/6.

Three active-low controls decide which clocks run. One parks the CPU clock low. One parks the gated PCI clock low. One powers everything down and overrides the other two. All of them are resynchronised into the master domain. An enable may change only on an edge where the output it gates is about to be low, so every output period is either whole or entirely missing. Leaving power-down starts a timed restart counter, and clocks reappear only after it has expired.

Top module: `clkgate_pwr_ctrl`

## Requirements
- R1: The mode is `{spd_sel, tri_test_n}`: 00 disables all four output enables (all four `*_oe` low); 01, 10 and 11 drive all four output enables high.
- R2: In mode 01 (slow), `cpu_clk` has a period of 3 master cycles and both PCI clocks have a period of 6 master cycles. A CPU rising edge falls on every PCI rising edge.
- R3: In mode 11 (fast), `cpu_clk` has a period of 2 master cycles and both PCI clocks have a period of 6 master cycles.
- R4: In mode 10 (test), `cpu_clk` is `tclk`/2, `pci_clk` and `pci_free_clk` are `tclk`/6, and `ref_clk` follows `tclk` with the same period.
- R5: In the slow and fast modes, `ref_clk` has a period of REF_DIV master cycles.
- R6: While `cpu_stop_n` is low, `cpu_clk` stays low and the other three clocks keep running.
- R7: While `pci_stop_n` is low, `pci_clk` stays low and `pci_free_clk` keeps running.
- R8: After a change of `cpu_stop_n` or `pci_stop_n`, at most one further `pci_free_clk` rising edge passes before the change shows. For a stop, this counts edges that still carry the gated clock. For a start, it counts edges that pass before the gated clock's first rise.
- R9: While `pwr_dn_n` is low, all four clocks stay low whatever the stop inputs are. At most 2 `pci_free_clk` rising edges occur after `pwr_dn_n` falls.
- R10: After `pwr_dn_n` rises, no `pci_free_clk` rising edge occurs for at least PWRUP_CYCLES master cycles.
- R11: Every high and low phase of every output has its full length. No shortened or stretched pulse appears on stopping, starting, powering down or restarting.
- R12: While `rst_n` is low, all four clocks are low. After reset the clocks run with no power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spd_sel | input | 1 | Speed select (mode bit 1) |
| tri_test_n | input | 1 | Active-low tristate/test select (mode bit 0) |
| tclk | input | 1 | External test clock, used in test mode |
| cpu_stop_n | input | 1 | Active-low CPU clock stop |
| pci_stop_n | input | 1 | Active-low gated PCI clock stop |
| pwr_dn_n | input | 1 | Active-low power-down |
| cpu_clk | output | 1 | CPU clock |
| pci_clk | output | 1 | Gated PCI clock |
| pci_free_clk | output | 1 | Free-running PCI clock |
| ref_clk | output | 1 | Reference clock |
| cpu_oe | output | 1 | Output enable for cpu_clk |
| pci_oe | output | 1 | Output enable for pci_clk |
| pci_free_oe | output | 1 | Output enable for pci_free_clk |
| ref_oe | output | 1 | Output enable for ref_clk |

## Verification
Each of the four mode codes is applied, and every output's period and high width are measured over a long window. These measurements distinguish the master/2 and master/3 CPU dividers, the master-derived sources from the test-clock source, and a clean waveform from one with an uneven pulse. The stop and start controls are toggled at several offsets inside the PCI period. The bench then counts free-running PCI edges around each toggle, which separates a gate that acts on the next boundary from one that is late or that cuts a pulse. Power-down is asserted with both stop inputs inactive, which shows that it overrides them. The restart gap is then timed against the configured delay.

// File: rtl/clkgate_pkg.sv
// Package: shared mode encoding and phase decode for the clock controller.
// Assumes a PCI period of six phase steps, numbered 0..5, with every
// output rising at phase 0.
package clkgate_pkg;

    // Mode code is {speed select, tristate/test pin}.
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_SLOW = 2'b01,
        MODE_TEST = 2'b10,
        MODE_FAST = 2'b11
    } clk_mode_e;

    localparam int PH_W = 3;
    localparam logic [PH_W-1:0] PH_LAST = 3'd5;

    // CPU level at a phase: master/3 in slow mode, master/2 otherwise.
    function automatic logic cpu_level(input clk_mode_e m, input logic [PH_W-1:0] p);
        if (m == MODE_SLOW) begin
            return (p != 3'd2) && (p != 3'd5);
        end
        return ~p[0];
    endfunction

    // PCI level at a phase: high for the first half of the period.
    function automatic logic pci_level(input logic [PH_W-1:0] p);
        return p < 3'd3;
    endfunction

endpackage

// File: rtl/cc_sync.sv
// Module: two-flop synchroniser for a vector of independent level inputs.
// Assumes every bit is a slow level or a clock much slower than clk.
module cc_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages per bit; reset loads the idle values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/cc_phase.sv
// Module: phase sequencer. Steps a 0..5 phase counter once per master cycle
// in the normal modes, or once per synchronised test-clock rise in test
// mode. It presents the next-phase clock levels and a pre-boundary strobe
// on the step that enters phase 5, where every divided clock is low.
// It also runs the reference divider.
// Assumes tclk_s is already synchronised to clk.
module cc_phase
    import clkgate_pkg::*;
#(
    parameter int REF_DIV = 14
) (
    input  logic      clk,
    input  logic      rst_n,
    input  clk_mode_e mode,
    input  logic      tclk_s,
    output logic      tick,
    output logic      pre,
    output logic      cpu_nx,
    output logic      pci_nx,
    output logic      ref_nx
);
    localparam int RC_W = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(REF_DIV - 1);
    localparam logic [RC_W-1:0] RC_HALF = RC_W'(REF_DIV / 2);

    logic [PH_W-1:0] ph, ph_next;
    logic [RC_W-1:0] rc, rc_next;
    logic            tclk_q;

    // Step strobe and next-phase decode.
    always_comb begin
        tick    = (mode == MODE_TEST) ? (tclk_s & ~tclk_q) : 1'b1;
        ph_next = (ph == PH_LAST) ? '0 : ph + 1'b1;
        pre     = tick && (ph_next == PH_LAST);
        cpu_nx  = cpu_level(mode, ph_next);
        pci_nx  = pci_level(ph_next);
        rc_next = (rc == RC_LAST) ? '0 : rc + 1'b1;
        ref_nx  = (mode == MODE_TEST) ? tclk_s : (rc_next < RC_HALF);
    end

    // Phase counter advances on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_LAST;
        end else if (tick) begin
            ph <= ph_next;
        end
    end

    // Reference divider and test-clock edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc     <= RC_LAST;
            tclk_q <= 1'b0;
        end else begin
            rc     <= rc_next;
            tclk_q <= tclk_s;
        end
    end

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= PH_LAST);
    assert_pre_then_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_TEST && pre) |=> (ph == PH_LAST));
endmodule

// File: rtl/cc_gate.sv
// Module: gate-enable control. Turns the synchronised stop and power inputs
// into per-output enables, which change only at a pre-boundary strobe
// (divided clocks) or while the next reference level is low. Holds all
// enables off through a power-up delay after power-down is released.
// Assumes pre coincides with all divided clocks going low.
module cc_gate #(
    parameter int PWRUP_CYCLES = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pre,
    input  logic ref_nx,
    input  logic cpu_run_s,
    input  logic pci_run_s,
    input  logic pwr_on_s,
    output logic cpu_en,
    output logic pci_en,
    output logic free_en,
    output logic ref_en
);
    localparam int PU_W = $clog2(PWRUP_CYCLES + 1);
    localparam logic [PU_W-1:0] PU_LOAD = PU_W'(PWRUP_CYCLES);

    logic [PU_W-1:0] pu_cnt;
    logic            ready;

    assign ready = pwr_on_s && (pu_cnt == '0);

    // Power-up delay: reload while down, count out after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_cnt <= '0;
        end else if (!pwr_on_s) begin
            pu_cnt <= PU_LOAD;
        end else if (pu_cnt != '0) begin
            pu_cnt <= pu_cnt - 1'b1;
        end
    end

    // Divided-clock enables move only at the pre-boundary strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_en  <= 1'b1;
            pci_en  <= 1'b1;
            free_en <= 1'b1;
        end else if (pre) begin
            cpu_en  <= ready & cpu_run_s;
            pci_en  <= ready & pci_run_s;
            free_en <= ready;
        end
    end

    // Reference enable moves only while the next reference level is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_en <= 1'b1;
        end else if (!ref_nx) begin
            ref_en <= ready;
        end
    end

    assert_cpu_under_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> free_en);
    assert_pci_under_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pci_en |-> free_en);
    assert_no_early_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(free_en) |-> ($past(pu_cnt) == '0 && $past(pwr_on_s)));
endmodule

// File: rtl/clkgate_pwr_ctrl.sv
// Module: top of the clock stop and power-down controller. Synchronises
// the strap and control inputs, runs the phase sequencer and gate control,
// and registers each clock output as (next level AND enable) so that
// outputs come straight from flops.
// Assumes the straps are static or change only rarely.
module clkgate_pwr_ctrl
    import clkgate_pkg::*;
#(
    parameter int REF_DIV      = 14,
    parameter int PWRUP_CYCLES = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spd_sel,
    input  logic tri_test_n,
    input  logic tclk,
    input  logic cpu_stop_n,
    input  logic pci_stop_n,
    input  logic pwr_dn_n,
    output logic cpu_clk,
    output logic pci_clk,
    output logic pci_free_clk,
    output logic ref_clk,
    output logic cpu_oe,
    output logic pci_oe,
    output logic pci_free_oe,
    output logic ref_oe
);
    localparam int NSYNC = 6;

    logic [NSYNC-1:0] raw_in, syn;
    clk_mode_e        mode;
    logic             tick, pre, cpu_nx, pci_nx, ref_nx;
    logic             cpu_en, pci_en, free_en, ref_en;
    logic             drive_on;

    assign raw_in = {tclk, pwr_dn_n, pci_stop_n, cpu_stop_n, tri_test_n, spd_sel};

    cc_sync #(.W(NSYNC), .RST_VAL(6'b011111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn)
    );

    assign mode = clk_mode_e'({syn[0], syn[1]});

    cc_phase #(.REF_DIV(REF_DIV)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .tclk_s (syn[5]),
        .tick   (tick),
        .pre    (pre),
        .cpu_nx (cpu_nx),
        .pci_nx (pci_nx),
        .ref_nx (ref_nx)
    );

    cc_gate #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre       (pre),
        .ref_nx    (ref_nx),
        .cpu_run_s (syn[2]),
        .pci_run_s (syn[3]),
        .pwr_on_s  (syn[4]),
        .cpu_en    (cpu_en),
        .pci_en    (pci_en),
        .free_en   (free_en),
        .ref_en    (ref_en)
    );

    // Divided clock outputs update on each phase step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_clk      <= 1'b0;
            pci_clk      <= 1'b0;
            pci_free_clk <= 1'b0;
        end else if (tick) begin
            cpu_clk      <= cpu_nx & cpu_en;
            pci_clk      <= pci_nx & pci_en;
            pci_free_clk <= pci_nx & free_en;
        end
    end

    // Reference output updates every master cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_clk <= 1'b0;
        end else begin
            ref_clk <= ref_nx & ref_en;
        end
    end

    assign drive_on    = (mode != MODE_OFF);
    assign cpu_oe      = drive_on;
    assign pci_oe      = drive_on;
    assign pci_free_oe = drive_on;
    assign ref_oe      = drive_on;

    assert_cpu_gate_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_en) |-> !cpu_clk);
    assert_pci_gate_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pci_en) |-> !pci_clk);
    assert_ref_gate_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_en) |-> !ref_clk);
endmodule

// File: tb/tb_clkgate_pwr_ctrl.sv
// Scoreboard bench: the driver queues expected measurements, and the
// monitor pops each one, measures the outputs and compares the result.
module tb_clkgate_pwr_ctrl;
    localparam int REF_DIV = 14;
    localparam int PU      = 300;

    localparam int K_RST = 0, K_OE = 1, K_CPU = 2, K_PCI = 3, K_FREE = 4, K_REF = 5;
    localparam int K_STOP_C = 6, K_START_C = 7, K_STOP_P = 8, K_START_P = 9;
    localparam int K_PD = 10, K_PU = 11;

    typedef struct {
        string tag;
        int    kind;
        int    lo;
        int    hi;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spd_sel = 1'b0, tri_test_n = 1'b1, tclk = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic cpu_clk, pci_clk, pci_free_clk, ref_clk;
    logic cpu_oe, pci_oe, pci_free_oe, ref_oe;

    item_t q[$];
    bit    busy = 1'b0;
    int    n_checks = 0, n_fail = 0;
    bit    finished = 1'b0;

    always #10 clk = ~clk;

    clkgate_pwr_ctrl #(.REF_DIV(REF_DIV), .PWRUP_CYCLES(PU)) dut (
        .clk(clk), .rst_n(rst_n), .spd_sel(spd_sel), .tri_test_n(tri_test_n),
        .tclk(tclk), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .pwr_dn_n(pwr_dn_n), .cpu_clk(cpu_clk), .pci_clk(pci_clk),
        .pci_free_clk(pci_free_clk), .ref_clk(ref_clk), .cpu_oe(cpu_oe),
        .pci_oe(pci_oe), .pci_free_oe(pci_free_oe), .ref_oe(ref_oe)
    );

    // Test clock: toggles every 5 master cycles, so its period is 10.
    initial begin
        forever begin
            repeat (5) @(negedge clk);
            tclk = ~tclk;
        end
    end

    function automatic logic pick(input int k);
        case (k)
            K_CPU:   return cpu_clk;
            K_PCI:   return pci_clk;
            K_FREE:  return pci_free_clk;
            default: return ref_clk;
        endcase
    endfunction

    // Period of one output over a window: 0 if always low, -1 if uneven or stuck high.
    task automatic measure_period(input int k, output int res);
        logic p, s;
        int last = -1, per = -1, hiw = -1, edges = 0;
        bit bad = 1'b0, seen_hi = 1'b0;
        @(negedge clk);
        p = pick(k);
        for (int i = 1; i <= 260; i++) begin
            @(negedge clk);
            s = pick(k);
            if (s) seen_hi = 1'b1;
            if (s && !p) begin
                if (last >= 0) begin
                    if (per < 0) per = i - last;
                    else if (per != i - last) bad = 1'b1;
                end
                last = i;
                edges++;
            end
            if (!s && p && last >= 0) begin
                if (hiw < 0) hiw = i - last;
                else if (hiw != i - last) bad = 1'b1;
            end
            p = s;
        end
        if (edges == 0) res = seen_hi ? -1 : 0;
        else if (bad || edges < 2) res = -1;
        else res = per;
    endtask

    // Edge counting around a stop/start or power-down stimulus.
    task automatic measure_edges(input int k, output int res);
        logic pf, pg, sf, sg;
        int cnt = 0;
        bit hit = 1'b0;
        @(negedge clk);
        pf = pci_free_clk;
        pg = (k == K_STOP_C || k == K_START_C) ? cpu_clk : pci_clk;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            sf = pci_free_clk;
            sg = (k == K_STOP_C || k == K_START_C) ? cpu_clk : pci_clk;
            if (sf && !pf) begin
                if (k == K_PD) cnt++;
                else if (k == K_STOP_C || k == K_STOP_P) begin
                    if (sg && !pg) cnt++;
                end else if (!hit) begin
                    if (sg && !pg) hit = 1'b1;
                    else cnt++;
                end
            end
            pf = sf;
            pg = sg;
        end
        res = ((k == K_START_C || k == K_START_P) && !hit) ? 99 : cnt;
    endtask

    // Monitor: pops expected items, measures, compares.
    initial begin
        item_t it;
        int    res;
        forever begin
            wait (q.size() != 0);
            it   = q.pop_front();
            busy = 1'b1;
            res  = -2;
            case (it.kind)
                K_RST: begin
                    @(negedge clk);
                    res = {28'd0, cpu_clk, pci_clk, pci_free_clk, ref_clk};
                end
                K_OE: begin
                    @(negedge clk);
                    res = {28'd0, cpu_oe, pci_oe, pci_free_oe, ref_oe};
                end
                K_CPU, K_PCI, K_FREE, K_REF: measure_period(it.kind, res);
                K_PU: begin
                    logic pf;
                    res = -1;
                    pf = pci_free_clk;
                    for (int i = 1; i <= PU + 100; i++) begin
                        @(negedge clk);
                        if (res < 0 && pci_free_clk && !pf) res = i;
                        pf = pci_free_clk;
                    end
                end
                default: measure_edges(it.kind, res);
            endcase
            n_checks++;
            if (res < it.lo || res > it.hi) begin
                n_fail++;
                $display("FAIL %s: actual %0d expected %0d..%0d", it.tag, res, it.lo, it.hi);
            end
            busy = 1'b0;
        end
    end

    // Driver: queue an expectation, apply the stimulus once measuring starts.
    task automatic expect_item(input string tag, input int kind, input int lo,
                               input int hi, input int stim);
        item_t it;
        it.tag = tag; it.kind = kind; it.lo = lo; it.hi = hi;
        q.push_back(it);
        wait (busy);
        case (stim)
            1: cpu_stop_n = 1'b0;
            2: cpu_stop_n = 1'b1;
            3: pci_stop_n = 1'b0;
            4: pci_stop_n = 1'b1;
            5: pwr_dn_n   = 1'b0;
            6: pwr_dn_n   = 1'b1;
            default: ;
        endcase
        wait (!busy);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic s, input logic t);
        spd_sel    = s;
        tri_test_n = t;
        settle(40);
    endtask

    initial begin
        settle(3);
        expect_item("R12 outputs low in reset", K_RST, 0, 0, 0);
        rst_n = 1'b1;
        set_mode(1'b0, 1'b1);
        expect_item("R12 running after reset", K_FREE, 6, 6, 0);
        expect_item("R1 enables on in slow mode", K_OE, 15, 15, 0);
        expect_item("R2 slow cpu period", K_CPU, 3, 3, 0);
        expect_item("R2 slow pci period", K_PCI, 6, 6, 0);
        expect_item("R2 edge alignment at cpu start", K_START_C, 0, 0, 0);
        expect_item("R5 ref period", K_REF, REF_DIV, REF_DIV, 0);

        set_mode(1'b1, 1'b1);
        expect_item("R3 fast cpu period", K_CPU, 2, 2, 0);
        expect_item("R3 fast free pci period", K_FREE, 6, 6, 0);

        for (int off = 0; off < 3; off++) begin
            settle(off * 2 + 1);
            expect_item("R8 cpu stop latency", K_STOP_C, 0, 1, 1);
            expect_item("R6 cpu parked low", K_CPU, 0, 0, 0);
            expect_item("R6 free pci runs", K_FREE, 6, 6, 0);
            expect_item("R6 ref runs", K_REF, REF_DIV, REF_DIV, 0);
            settle(off + 2);
            expect_item("R8 cpu start latency", K_START_C, 0, 1, 2);
            expect_item("R11 cpu whole pulses after start", K_CPU, 2, 2, 0);
        end

        settle(4);
        expect_item("R8 pci stop latency", K_STOP_P, 0, 1, 3);
        expect_item("R7 pci parked low", K_PCI, 0, 0, 0);
        expect_item("R7 free pci runs", K_FREE, 6, 6, 0);
        expect_item("R7 cpu runs", K_CPU, 2, 2, 0);
        expect_item("R8 pci start latency", K_START_P, 0, 1, 4);
        expect_item("R11 pci whole pulses after start", K_PCI, 6, 6, 0);

        set_mode(1'b0, 1'b1);
        expect_item("R9 power-down halt edges", K_PD, 0, 2, 5);
        expect_item("R9 cpu low in power-down", K_CPU, 0, 0, 0);
        expect_item("R9 pci low in power-down", K_PCI, 0, 0, 0);
        expect_item("R9 free pci low in power-down", K_FREE, 0, 0, 0);
        expect_item("R9 ref low in power-down", K_REF, 0, 0, 0);
        expect_item("R10 restart delay", K_PU, PU, PU + 20, 6);
        expect_item("R11 cpu whole after restart", K_CPU, 3, 3, 0);
        expect_item("R11 ref whole after restart", K_REF, REF_DIV, REF_DIV, 0);

        set_mode(1'b1, 1'b0);
        settle(40);
        expect_item("R4 test cpu tclk/2", K_CPU, 20, 20, 0);
        expect_item("R4 test pci tclk/6", K_PCI, 60, 60, 0);
        expect_item("R4 test free pci tclk/6", K_FREE, 60, 60, 0);
        expect_item("R4 test ref follows tclk", K_REF, 10, 10, 0);

        set_mode(1'b0, 1'b0);
        expect_item("R1 enables off in disabled mode", K_OE, 0, 0, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule